// File: doc/BRIEF.md
# Request-Paced Master DMA Channel

A single-direction DMA channel that copies words from an external slave device, such as a data converter, into on-chip memory. The device paces the channel. Each time its request line goes high, the channel reads exactly one word from the device address, writes that word to the current internal address, and then stops to wait for the next request. The channel waits even while its transfer count is still nonzero.

A host loads six registers through a simple write port: an internal address, an internal step, an external address, an external step, a transfer count and a control word. Both steps are two's-complement values. An external step of 0 keeps reading one device register. An internal step of 1 stores the samples in consecutive locations. When the transfer that empties the count finishes, a sticky completion interrupt is raised.

Top module: `paced_dma_channel`

## Requirements
- R1: Each accepted request produces exactly one word transfer. `ext_rd` stays high for WAIT_CYC+1 cycles (3 cycles by default). In the next cycle `mem_we` is high for a single cycle, and `mem_wdata` then carries the `ext_rdata` value sampled in the last strobe cycle.
- R2: The count drops by one at the end of each transfer. `done_irq` rises only when a transfer completes with the count at 1. With a count of N it rises after the N-th transfer and not before.
- R3: After a transfer the channel returns to idle and starts nothing until `dev_req` goes low and then high again. A request held high for many cycles yields a single transfer.
- R4: After each transfer the internal address (`mem_addr`) changes by the signed internal step, modulo 2^AW. A step of 0xFFFF means -1, and 0xFFFF + 1 wraps to 0x0000.
- R5: After each transfer the external address (`ext_addr`) changes by the signed external step, modulo 2^AW. A step of 0 reads every sample from the same address.
- R6: A request that arrives while the count is zero or the enable bit is clear produces no strobe and no write, and it leaves `ext_addr`, `mem_addr` and `done_irq` unchanged.
- R7: `done_irq` stays set until the host writes the control word with bit 1 set, or writes the count register.
- R8: Clearing the enable bit while a transfer is under way lets that transfer finish with its memory write. No later request starts a transfer.
- R9: Register select codes on `host_sel`:
  - 0: internal address
  - 1: internal step
  - 2: external address
  - 3: external step
  - 4: count
  - 5: control (bit 0 enable, bit 1 clear interrupt when written as 1)
  
  A write takes effect at the clock edge on which `host_we` is high. The addresses are visible at once on `mem_addr` and `ext_addr`.
- R10: After reset `ext_rd`, `mem_we`, `done_irq` and `busy` are low, the channel is disabled and the count is zero.
- R11: `dev_req` passes through a two-stage synchroniser. If it rises between clock edges 0 and 1, `ext_rd` first goes high after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select code |
| host_wdata | input | DW | Host write data |
| dev_req | input | 1 | Asynchronous transfer request from the device |
| ext_addr | output | AW | Current external (device) address |
| ext_rd | output | 1 | External read strobe |
| ext_rdata | input | DW | Data returned by the device |
| mem_addr | output | AW | Current internal memory address |
| mem_we | output | 1 | Internal memory write enable, one cycle per word |
| mem_wdata | output | DW | Word written to internal memory |
| done_irq | output | 1 | Sticky completion interrupt |
| busy | output | 1 | A transfer is in progress |

## Verification
The hardest case to reach is a disable that lands while a read strobe is already active. The stimulus raises a request and watches the ports until `ext_rd` goes high. It then issues the control write in the middle of the wait cycles and confirms that the scoreboarded memory write still arrives and that a fresh request is refused. The rest of the stimulus covers:
- a request held high well past one transfer, which must not start a second transfer
- a negative external step and an internal address that crosses the top of the address space
- requests made after the count is exhausted, whose lack of effect is checked on the address outputs and the interrupt

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   typedef enum logic [2:0] {
      SEL_IADDR = 3'd0,
      SEL_ISTEP = 3'd1,
      SEL_EADDR = 3'd2,
      SEL_ESTEP = 3'd3,
      SEL_COUNT = 3'd4,
      SEL_CTRL  = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } xfer_state_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/pdma_req_sync.sv
module pdma_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pdma_req_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], async_in};
         last_q <= chain[STAGES-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~last_q;

   // R3: an edge pulse never lasts two cycles
   assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
   import pdma_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [2:0]    host_sel,
   input  logic [DW-1:0] host_wdata,
   input  logic          xfer_done,
   output logic [AW-1:0] iaddr_o,
   output logic [AW-1:0] eaddr_o,
   output logic          enable_o,
   output logic          cnt_nz_o,
   output logic          irq_o
);

   generate
      if (AW > DW) begin : g_bad_aw
         $error("pdma_regs: AW must not exceed DW");
      end
      if (CW > DW) begin : g_bad_cw
         $error("pdma_regs: CW must not exceed DW");
      end
   endgenerate

   logic [AW-1:0] istep, estep;
   logic [CW-1:0] cnt;
   logic wr_ia, wr_is, wr_ea, wr_es, wr_cnt, wr_ctrl, clr_req;

   assign wr_ia   = host_we && (host_sel == SEL_IADDR);
   assign wr_is   = host_we && (host_sel == SEL_ISTEP);
   assign wr_ea   = host_we && (host_sel == SEL_EADDR);
   assign wr_es   = host_we && (host_sel == SEL_ESTEP);
   assign wr_cnt  = host_we && (host_sel == SEL_COUNT);
   assign wr_ctrl = host_we && (host_sel == SEL_CTRL);
   assign clr_req = wr_ctrl && host_wdata[CTRL_CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)         iaddr_o <= '0;
      else if (wr_ia)     iaddr_o <= host_wdata[AW-1:0];
      else if (xfer_done) iaddr_o <= iaddr_o + istep;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         eaddr_o <= '0;
      else if (wr_ea)     eaddr_o <= host_wdata[AW-1:0];
      else if (xfer_done) eaddr_o <= eaddr_o + estep;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         istep <= '0;
         estep <= '0;
      end else begin
         if (wr_is) istep <= host_wdata[AW-1:0];
         if (wr_es) estep <= host_wdata[AW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt <= '0;
      else if (wr_cnt)                cnt <= host_wdata[CW-1:0];
      else if (xfer_done && cnt != 0) cnt <= cnt - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       enable_o <= 1'b0;
      else if (wr_ctrl) enable_o <= host_wdata[CTRL_EN_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_o <= 1'b0;
      else if (xfer_done && cnt == CW'(1) && !wr_cnt)
         irq_o <= 1'b1;
      else if (wr_cnt || clr_req)
         irq_o <= 1'b0;
   end

   assign cnt_nz_o = |cnt;

   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !wr_cnt && cnt != 0) |=> (cnt == $past(cnt) - CW'(1)));

   assert_irq_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(xfer_done) && cnt == 0));

   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !wr_cnt && !clr_req) |=> irq_o);

endmodule

// File: rtl/pdma_xfer_fsm.sv
module pdma_xfer_fsm
   import pdma_pkg::*;
#(
   parameter int DW       = 16,
   parameter int WAIT_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          enable_i,
   input  logic          cnt_nz_i,
   input  logic [DW-1:0] ext_rdata_i,
   output logic          ext_rd_o,
   output logic          mem_we_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          xfer_done_o,
   output logic          busy_o
);

   localparam int WW = $clog2(WAIT_CYC + 1) + 1;

   xfer_state_e   st;
   logic [DW-1:0] cap;
   logic          read_last;

   generate
      if (WAIT_CYC < 0) begin : g_bad_wait
         $error("pdma_xfer_fsm: WAIT_CYC must be non-negative");
      end
      if (WAIT_CYC == 0) begin : g_nowait
         assign read_last = 1'b1;
      end else begin : g_wait
         logic [WW-1:0] wcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                       wcnt <= '0;
            else if (st == ST_READ && !read_last) wcnt <= wcnt + WW'(1);
            else                              wcnt <= '0;
         end
         assign read_last = (wcnt == WW'(WAIT_CYC));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
      end else begin
         unique case (st)
            ST_IDLE:  if (start_i && enable_i && cnt_nz_i) st <= ST_READ;
            ST_READ:  if (read_last) st <= ST_WRITE;
            ST_WRITE: st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         cap <= '0;
      else if (st == ST_READ && read_last) cap <= ext_rdata_i;
   end

   assign ext_rd_o    = (st == ST_READ);
   assign mem_we_o    = (st == ST_WRITE);
   assign xfer_done_o = mem_we_o;
   assign mem_wdata_o = cap;
   assign busy_o      = (st != ST_IDLE);

   assert_write_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(ext_rd_o));

   assert_write_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);

   assert_start_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_rd_o) |-> $past(start_i));

   assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_rd_o) |-> $past(enable_i && cnt_nz_i));

endmodule

// File: rtl/paced_dma_channel.sv
module paced_dma_channel #(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int CW          = 16,
   parameter int WAIT_CYC    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [2:0]    host_sel,
   input  logic [DW-1:0] host_wdata,
   input  logic          dev_req,
   output logic [AW-1:0] ext_addr,
   output logic          ext_rd,
   input  logic [DW-1:0] ext_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          done_irq,
   output logic          busy
);

   logic req_rise, xfer_done, enable, cnt_nz;

   pdma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (dev_req),
      .rise_o   (req_rise)
   );

   pdma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .xfer_done  (xfer_done),
      .iaddr_o    (mem_addr),
      .eaddr_o    (ext_addr),
      .enable_o   (enable),
      .cnt_nz_o   (cnt_nz),
      .irq_o      (done_irq)
   );

   pdma_xfer_fsm #(.DW(DW), .WAIT_CYC(WAIT_CYC)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (req_rise),
      .enable_i    (enable),
      .cnt_nz_i    (cnt_nz),
      .ext_rdata_i (ext_rdata),
      .ext_rd_o    (ext_rd),
      .mem_we_o    (mem_we),
      .mem_wdata_o (mem_wdata),
      .xfer_done_o (xfer_done),
      .busy_o      (busy)
   );

   assert_stopped_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !busy) |=> !ext_rd);

   assert_ext_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd && !host_we) |=> $stable(ext_addr));

endmodule

// File: tb/tb_paced_dma_channel.sv
`timescale 1ns/1ps
module tb_paced_dma_channel;
   localparam int AW = 16, DW = 16, CW = 16, WC = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, host_we, dev_req, ext_rd, mem_we, done_irq, busy;
   logic [2:0] host_sel;
   logic [DW-1:0] host_wdata, ext_rdata, mem_wdata;
   logic [AW-1:0] ext_addr, mem_addr;

   paced_dma_channel #(.AW(AW), .DW(DW), .CW(CW), .WAIT_CYC(WC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .dev_req(dev_req), .ext_addr(ext_addr),
      .ext_rd(ext_rd), .ext_rdata(ext_rdata), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .done_irq(done_irq), .busy(busy)
   );

   typedef struct { logic [AW-1:0] ia; logic [AW-1:0] ea; logic [DW-1:0] d; } item_t;
   item_t q[$];

   int checks = 0, errors = 0, rd_edges = 0, wr_pulses = 0, rd_len = 0;
   logic [AW-1:0] exp_i = '0, exp_e = '0, step_i = '0, step_e = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [2:0] sel, input logic [DW-1:0] data);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_wdata = data;
      @(negedge clk);
      host_we = 1'b0;
      case (sel)
         3'd0: exp_i  = data;
         3'd1: step_i = data;
         3'd2: exp_e  = data;
         3'd3: step_e = data;
         default: ;
      endcase
   endtask

   task automatic push_expect(input logic [DW-1:0] data);
      item_t it;
      it.ia = exp_i; it.ea = exp_e; it.d = data;
      q.push_back(it);
      exp_i = exp_i + step_i;
      exp_e = exp_e + step_e;
   endtask

   task automatic sample(input logic [DW-1:0] data, input int hold);
      @(negedge clk);
      ext_rdata = data;
      push_expect(data);
      dev_req = 1'b1;
      repeat (hold) @(negedge clk);
      dev_req = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic bare_request();
      @(negedge clk);
      dev_req = 1'b1;
      repeat (10) @(negedge clk);
      dev_req = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // monitor: strobe length and scoreboard compare
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (ext_rd) rd_len++;
         else if (rd_len != 0) begin
            check("R1 strobe length", rd_len, WC + 1);
            rd_edges++;
            rd_len = 0;
         end
         if (mem_we) begin
            wr_pulses++;
            if (q.size() == 0) check("R1 unexpected write", 1, 0);
            else begin
               item_t it;
               it = q.pop_front();
               check("R4 mem_addr", mem_addr, it.ia);
               check("R5 ext_addr", ext_addr, it.ea);
               check("R1 mem_wdata", mem_wdata, it.d);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check("watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int r0, w0;
      logic [AW-1:0] ea0, ma0;
      rst_n = 1'b0; host_we = 1'b0; host_sel = '0; host_wdata = '0;
      dev_req = 1'b0; ext_rdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 ext_rd", ext_rd, 0);
      check("R10 mem_we", mem_we, 0);
      check("R10 done_irq", done_irq, 0);
      check("R10 busy", busy, 0);
      bare_request();   // disabled, count zero
      check("R10 no transfer after reset", rd_edges, 0);

      host_write(3'd0, 16'h0100);
      check("R9 mem_addr load", mem_addr, 16'h0100);
      host_write(3'd1, 16'h0001);
      host_write(3'd2, 16'h4000);
      check("R9 ext_addr load", ext_addr, 16'h4000);
      host_write(3'd3, 16'h0000);
      host_write(3'd4, 16'd4);
      host_write(3'd5, 16'h0001);

      // R11 latency, first sample
      @(negedge clk);
      ext_rdata = 16'hA001;
      push_expect(16'hA001);
      dev_req = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      check("R11 no strobe before edge 3", ext_rd, 0);
      @(negedge clk);
      check("R11 strobe after edge 3", ext_rd, 1);
      repeat (8) @(negedge clk);
      dev_req = 1'b0;
      repeat (4) @(negedge clk);

      sample(16'hA002, 10);
      sample(16'hA003, 10);
      check("R2 no irq before last", done_irq, 0);
      r0 = rd_edges;
      sample(16'hA004, 25);  // held high long
      check("R3 held request one transfer", rd_edges - r0, 1);
      check("R2 irq after count", done_irq, 1);

      // count exhausted: ignored
      r0 = rd_edges; ea0 = ext_addr; ma0 = mem_addr;
      bare_request();
      check("R6 no strobe at zero count", rd_edges - r0, 0);
      check("R6 ext_addr unchanged", ext_addr, ea0);
      check("R6 mem_addr unchanged", mem_addr, ma0);
      check("R7 irq stays set", done_irq, 1);
      host_write(3'd5, 16'h0003);
      check("R7 irq cleared by control", done_irq, 0);

      // wrap and negative external step
      host_write(3'd0, 16'hFFFE);
      host_write(3'd2, 16'h0010);
      host_write(3'd3, 16'hFFFE);
      host_write(3'd4, 16'd3);
      sample(16'h5A01, 10);
      sample(16'h5A02, 10);
      sample(16'h5A03, 10);
      check("R4 wrapped address", mem_addr, 16'h0001);
      check("R5 negative step", ext_addr, 16'h000A);
      check("R2 irq second batch", done_irq, 1);
      host_write(3'd4, 16'd2);
      check("R7 irq cleared by count reload", done_irq, 0);

      // disabled: ignored
      host_write(3'd5, 16'h0000);
      r0 = rd_edges; ea0 = ext_addr;
      bare_request();
      check("R6 no strobe while disabled", rd_edges - r0, 0);
      check("R6 ext_addr unchanged disabled", ext_addr, ea0);
      host_write(3'd5, 16'h0001);

      host_write(3'd1, 16'hFFFF);
      sample(16'h7E01, 10);
      check("R4 negative step", mem_addr, 16'h0000);

      // R8 disable during transfer
      host_write(3'd4, 16'd2);
      w0 = wr_pulses;
      @(negedge clk);
      ext_rdata = 16'hC0DE;
      push_expect(16'hC0DE);
      dev_req = 1'b1;
      while (!ext_rd) @(negedge clk);
      host_we = 1'b1; host_sel = 3'd5; host_wdata = 16'h0000;
      @(negedge clk);
      host_we = 1'b0;
      repeat (8) @(negedge clk);
      dev_req = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 in-flight transfer completes", wr_pulses - w0, 1);
      r0 = rd_edges;
      bare_request();
      check("R8 no new transfer after stop", rd_edges - r0, 0);

      repeat (4) @(negedge clk);
      check("R1 scoreboard drained", q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule